// File: doc/BRIEF.md
# Synchronous Serial Transceiver

This block is a clocked serial port that moves byte-sized characters over three lines: a transmit data output, a receive data input and a serial clock shared by both directions. Each direction keeps one character of buffering. The host writes the next character into a holding register while the current one is still shifting out. The receiver keeps its last complete character in a read buffer while the next one is shifting in.

The serial clock has two sources. An internal divider of the system clock can generate it, and the clock pin is then driven as an output. The clock can also come from the far end, in which case the pin is an input and its edges are synchronised into the system clock domain. A small register-style host port reads and writes characters and reports four status flags: transmit holding register empty, transmit in progress, receive buffer full and receive overrun. The frame format is selectable: 7, 8 or 9 data bits, followed by one or two stop bits.

Top module: `sync_serial_port`

## Requirements
- R1: After reset, tx_empty is 1, and tx_busy, rx_full and rx_overrun are 0. ser_txd is 1 and ser_clk_out is 0. With the internal clock selected and nothing to send, ser_clk_out stays at 0 and ser_txd stays at 1.
- R2: A transmitted frame has four parts, in order. It starts with one low start bit. The data bits follow, least significant bit first; cfg_fmt 00 gives 7 of them, 01 gives 8, 10 gives 9 and 11 gives 8. One stop bit follows, or two when cfg_two_stop is 1, and each stop bit is high. ser_txd changes only in response to a rising serial-clock edge.
- R3: With cfg_ext_clk at 0, ser_clk_oe is 1. Each half period of ser_clk_out lasts cfg_div+1 system cycles. The clock gives exactly one rising edge per frame bit, and when no character is pending it returns to and stays at 0.
- R4: The receiver samples ser_rxd on falling serial-clock edges. A character is complete after as many falling edges as the frame has bits. The read buffer then holds the data bits in order, starting at bit 0, and the unused upper bits are 0.
- R5: tx_empty goes to 0 when the host writes a character. It returns to 1 when that character moves into the transmit shifter.
- R6: tx_busy is 1 from the start of a character until its last stop bit has been sampled with the holding register empty. A character written while another is being sent follows it without any idle clock period, and tx_busy does not drop between the two.
- R7: rx_full goes to 1 when a character completes. It goes to 0 when the host reads the data address.
- R8: When a character completes while rx_full is still 1, the buffer takes the new character and rx_overrun goes to 1. rx_overrun stays at 1 until the host writes the status address with bit 3 set; a write to that address with bit 3 clear has no effect on it.
- R9: With cfg_ext_clk at 1, ser_clk_oe is 0 and ser_clk_out stays at 0. Transmit bits follow the rising edges of ser_clk_in, and receive bits are taken on its falling edges.
- R10: The host port has two addresses. Address 0 takes transmit characters on write and returns the receive buffer on read. Address 1 returns the status on read: bit 0 tx_empty, bit 1 tx_busy, bit 2 rx_full, bit 3 rx_overrun, and the other bits 0. Read data appears on host_rdata on the cycle after host_rd.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_ext_clk | input | 1 | 1: serial clock from ser_clk_in; 0: internal divider |
| cfg_fmt | input | 2 | Data length code (00=7, 01=8, 10=9, 11=8) |
| cfg_two_stop | input | 1 | 1: two stop bits; 0: one |
| cfg_div | input | DIV_W | Internal clock half period minus one, in system cycles |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | 2 | Host address (0 data, 1 status) |
| host_wdata | input | 9 | Host write data |
| host_rdata | output | 9 | Registered host read data |
| tx_empty | output | 1 | Transmit holding register empty |
| tx_busy | output | 1 | Transmission in progress |
| rx_full | output | 1 | Receive buffer holds an unread character |
| rx_overrun | output | 1 | Sticky receive overrun |
| ser_txd | output | 1 | Serial transmit data |
| ser_rxd | input | 1 | Serial receive data |
| ser_clk_in | input | 1 | External serial clock |
| ser_clk_out | output | 1 | Generated serial clock |
| ser_clk_oe | output | 1 | Clock pin output enable |

## Verification
Some properties are checked on every cycle. The transmit line moves only after a rising serial-clock edge, and the generated clock rests low whenever nothing is being sent or the external source is selected. A pending holding register always forces the transmitter busy, and busy never drops while a character waits or while the line is low. Each clear of tx_empty, rx_full and rx_overrun must trace back to the matching host access. Other behaviour only the directed scenarios can show: the exact bit order and length of each frame format, the half-period timing of the divider, the data that lands in the receive buffer in both clock modes, the gap-free back-to-back sequence, and the overwrite that an overrun causes.

// File: rtl/ssp_pkg.sv
`timescale 1ns/1ps
package ssp_pkg;
  localparam int DATA_W    = 9;
  localparam int STOP_MAX  = 2;
  localparam int FRAME_MAX = 1 + DATA_W + STOP_MAX;
  localparam int CNT_W     = $clog2(FRAME_MAX + 1);

  typedef logic [CNT_W-1:0] cnt_t;

  localparam logic [1:0] ADDR_DATA = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam int STAT_OVR_BIT = 3;

  // data length from format code; 11 falls back to eight bits
  function automatic cnt_t data_len(input logic [1:0] fmt);
    case (fmt)
      2'b00:   data_len = cnt_t'(7);
      2'b10:   data_len = cnt_t'(9);
      default: data_len = cnt_t'(8);
    endcase
  endfunction

  function automatic cnt_t frame_len(input logic [1:0] fmt, input logic two_stop);
    frame_len = cnt_t'(1) + data_len(fmt) + (two_stop ? cnt_t'(2) : cnt_t'(1));
  endfunction

  // bit 0 = start, then data LSB first, remaining positions high
  function automatic logic [FRAME_MAX-1:0] build_frame(input logic [DATA_W-1:0] d,
                                                       input logic [1:0] fmt);
    logic [FRAME_MAX-1:0] f;
    cnt_t n;
    n = data_len(fmt);
    f = '1;
    f[0] = 1'b0;
    for (int i = 0; i < DATA_W; i++) begin
      if (cnt_t'(i) < n) f[i+1] = d[i];
    end
    build_frame = f;
  endfunction
endpackage

// File: rtl/ssp_sync.sv
`timescale 1ns/1ps
module ssp_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] st;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) st[i] <= RST_VAL;
        else     st[i] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) st[i] <= RST_VAL;
        else     st[i] <= st[i-1];
      end
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/ssp_clkgen.sv
`timescale 1ns/1ps
module ssp_clkgen #(
  parameter int DIV_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ext_sel,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  input  logic             clk_in,
  output logic             clk_out,
  output logic             clk_oe,
  output logic             rise_ev,
  output logic             fall_ev
);
  logic [DIV_W-1:0] cnt;
  logic             sclk;
  logic             int_rise, int_fall;
  logic             ext_s, ext_prev, ext_rise, ext_fall;

  // internal divider: toggles every div+1 cycles while running, rests low
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      sclk     <= 1'b0;
      int_rise <= 1'b0;
      int_fall <= 1'b0;
    end else begin
      int_rise <= 1'b0;
      int_fall <= 1'b0;
      if (!ext_sel && run) begin
        if (cnt == div) begin
          cnt      <= '0;
          sclk     <= ~sclk;
          int_rise <= ~sclk;
          int_fall <= sclk;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end else begin
        cnt  <= '0;
        sclk <= 1'b0;
      end
    end
  end

  ssp_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_clk_sync (
    .clk (clk),
    .rst (rst),
    .d   (clk_in),
    .q   (ext_s)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ext_prev <= 1'b0;
      ext_rise <= 1'b0;
      ext_fall <= 1'b0;
      clk_oe   <= 1'b1;
    end else begin
      ext_prev <= ext_s;
      ext_rise <= ext_s & ~ext_prev;
      ext_fall <= ~ext_s & ext_prev;
      clk_oe   <= ~ext_sel;
    end
  end

  assign clk_out = sclk;
  assign rise_ev = ext_sel ? ext_rise : int_rise;
  assign fall_ev = ext_sel ? ext_fall : int_fall;
endmodule

// File: rtl/ssp_tx.sv
`timescale 1ns/1ps
module ssp_tx
  import ssp_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_load,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        fmt,
  input  logic              two_stop,
  input  logic              rise_ev,
  input  logic              fall_ev,
  output logic              txd,
  output logic              tx_empty,
  output logic              tx_busy
);
  logic [DATA_W-1:0]    hold;
  logic [FRAME_MAX-1:0] shreg;
  cnt_t                 bitcnt;
  cnt_t                 flen;
  logic                 bit_out;

  assign flen = frame_len(fmt, two_stop);

  always_ff @(posedge clk) begin
    if (rst) begin
      hold     <= '0;
      shreg    <= '1;
      bitcnt   <= '0;
      bit_out  <= 1'b0;
      txd      <= 1'b1;
      tx_empty <= 1'b1;
      tx_busy  <= 1'b0;
    end else begin
      if (!tx_busy && !tx_empty) begin
        tx_busy  <= 1'b1;
        shreg    <= build_frame(hold, fmt);
        bitcnt   <= '0;
        bit_out  <= 1'b0;
        tx_empty <= 1'b1;
      end else if (tx_busy && rise_ev) begin
        txd     <= shreg[0];
        shreg   <= {1'b1, shreg[FRAME_MAX-1:1]};
        bit_out <= 1'b1;
      end else if (tx_busy && fall_ev && bit_out) begin
        bit_out <= 1'b0;
        if (bitcnt == flen - cnt_t'(1)) begin
          if (!tx_empty) begin
            shreg    <= build_frame(hold, fmt);
            bitcnt   <= '0;
            tx_empty <= 1'b1;
          end else begin
            tx_busy <= 1'b0;
          end
        end else begin
          bitcnt <= bitcnt + cnt_t'(1);
        end
      end
      // a host write wins over a same-cycle transfer
      if (wr_load) begin
        hold     <= wr_data;
        tx_empty <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ssp_rx.sv
`timescale 1ns/1ps
module ssp_rx
  import ssp_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rxd,
  input  logic              fall_ev,
  input  logic [1:0]        fmt,
  input  logic              two_stop,
  input  logic              pop,
  input  logic              ovr_clr,
  output logic [DATA_W-1:0] rx_buf,
  output logic              rx_full,
  output logic              rx_ovr
);
  logic              rxd_s;
  logic [DATA_W-1:0] data;
  cnt_t              idx;
  cnt_t              flen;
  cnt_t              ndata;
  logic              done;

  ssp_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_rxd_sync (
    .clk (clk),
    .rst (rst),
    .d   (rxd),
    .q   (rxd_s)
  );

  assign flen  = frame_len(fmt, two_stop);
  assign ndata = data_len(fmt);
  assign done  = fall_ev && (idx == flen - cnt_t'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      idx  <= '0;
      data <= '0;
    end else if (fall_ev) begin
      idx <= done ? '0 : idx + cnt_t'(1);
      if (idx == '0) begin
        data <= '0;
      end else begin
        for (int i = 0; i < DATA_W; i++) begin
          if (idx == cnt_t'(i + 1) && cnt_t'(i) < ndata) data[i] <= rxd_s;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_buf  <= '0;
      rx_full <= 1'b0;
      rx_ovr  <= 1'b0;
    end else begin
      if (done) begin
        rx_buf  <= data;
        rx_full <= 1'b1;
      end else if (pop) begin
        rx_full <= 1'b0;
      end
      if (done && rx_full && !pop) rx_ovr <= 1'b1;
      else if (ovr_clr)            rx_ovr <= 1'b0;
    end
  end
endmodule

// File: rtl/sync_serial_port.sv
`timescale 1ns/1ps
module sync_serial_port
  import ssp_pkg::*;
#(
  parameter int DIV_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_ext_clk,
  input  logic [1:0]        cfg_fmt,
  input  logic              cfg_two_stop,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [1:0]        host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              tx_empty,
  output logic              tx_busy,
  output logic              rx_full,
  output logic              rx_overrun,
  output logic              ser_txd,
  input  logic              ser_rxd,
  input  logic              ser_clk_in,
  output logic              ser_clk_out,
  output logic              ser_clk_oe
);
  logic              ev_rise, ev_fall;
  logic [DATA_W-1:0] rx_buf;
  logic              wr_data_sel, rd_data_sel, ovr_clr;

  assign wr_data_sel = host_wr && (host_addr == ADDR_DATA);
  assign rd_data_sel = host_rd && (host_addr == ADDR_DATA);
  assign ovr_clr     = host_wr && (host_addr == ADDR_STAT) && host_wdata[STAT_OVR_BIT];

  ssp_clkgen #(.DIV_W(DIV_W), .SYNC_STAGES(SYNC_STAGES)) u_clkgen (
    .clk     (clk),
    .rst     (rst),
    .ext_sel (cfg_ext_clk),
    .run     (tx_busy),
    .div     (cfg_div),
    .clk_in  (ser_clk_in),
    .clk_out (ser_clk_out),
    .clk_oe  (ser_clk_oe),
    .rise_ev (ev_rise),
    .fall_ev (ev_fall)
  );

  ssp_tx u_tx (
    .clk      (clk),
    .rst      (rst),
    .wr_load  (wr_data_sel),
    .wr_data  (host_wdata),
    .fmt      (cfg_fmt),
    .two_stop (cfg_two_stop),
    .rise_ev  (ev_rise),
    .fall_ev  (ev_fall),
    .txd      (ser_txd),
    .tx_empty (tx_empty),
    .tx_busy  (tx_busy)
  );

  ssp_rx #(.SYNC_STAGES(SYNC_STAGES)) u_rx (
    .clk      (clk),
    .rst      (rst),
    .rxd      (ser_rxd),
    .fall_ev  (ev_fall),
    .fmt      (cfg_fmt),
    .two_stop (cfg_two_stop),
    .pop      (rd_data_sel),
    .ovr_clr  (ovr_clr),
    .rx_buf   (rx_buf),
    .rx_full  (rx_full),
    .rx_ovr   (rx_overrun)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      host_rdata <= '0;
    end else if (host_rd) begin
      case (host_addr)
        ADDR_DATA: host_rdata <= rx_buf;
        ADDR_STAT: host_rdata <= {{(DATA_W-4){1'b0}}, rx_overrun, rx_full, tx_busy, tx_empty};
        default:   host_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/ssp_checker.sv
`timescale 1ns/1ps
module ssp_checker (
  input logic       clk,
  input logic       rst,
  input logic       cfg_ext_clk,
  input logic       host_wr,
  input logic       host_rd,
  input logic [1:0] host_addr,
  input logic       wbit_ovr,
  input logic       tx_empty,
  input logic       tx_busy,
  input logic       rx_full,
  input logic       rx_overrun,
  input logic       ser_txd,
  input logic       ser_clk_out,
  input logic       ev_rise
);
  assert_txd_on_rise_R2: assert property (@(posedge clk) disable iff (rst)
    (ser_txd != $past(ser_txd)) |-> $past(ev_rise));

  assert_clk_idle_low_R3: assert property (@(posedge clk) disable iff (rst)
    (!cfg_ext_clk && !tx_busy) |-> !ser_clk_out);

  assert_ext_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    cfg_ext_clk |=> !ser_clk_out);

  assert_pending_busy_R6: assert property (@(posedge clk) disable iff (rst)
    !tx_empty |=> tx_busy);

  assert_busy_drop_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(tx_busy) |-> (tx_empty && ser_txd));

  assert_empty_clear_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(tx_empty) |-> $past(host_wr && host_addr == 2'd0));

  assert_rxfull_clear_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(rx_full) |-> $past(host_rd && host_addr == 2'd0));

  assert_ovr_clear_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(rx_overrun) |-> $past(host_wr && host_addr == 2'd1 && wbit_ovr));
endmodule

bind sync_serial_port ssp_checker u_chk (
  .clk         (clk),
  .rst         (rst),
  .cfg_ext_clk (cfg_ext_clk),
  .host_wr     (host_wr),
  .host_rd     (host_rd),
  .host_addr   (host_addr),
  .wbit_ovr    (host_wdata[3]),
  .tx_empty    (tx_empty),
  .tx_busy     (tx_busy),
  .rx_full     (rx_full),
  .rx_overrun  (rx_overrun),
  .ser_txd     (ser_txd),
  .ser_clk_out (ser_clk_out),
  .ev_rise     (ev_rise)
);

// File: tb/sync_serial_port_tb.sv
`timescale 1ns/1ps
module sync_serial_port_tb;
  localparam int DIV_W = 16;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             cfg_ext_clk = 1'b0;
  logic [1:0]       cfg_fmt = 2'b01;
  logic             cfg_two_stop = 1'b0;
  logic [DIV_W-1:0] cfg_div = 16'd4;
  logic             host_wr = 1'b0, host_rd = 1'b0;
  logic [1:0]       host_addr = 2'd0;
  logic [8:0]       host_wdata = '0;
  logic [8:0]       host_rdata;
  logic             tx_empty, tx_busy, rx_full, rx_overrun;
  logic             ser_txd, ser_rxd, ser_clk_out, ser_clk_oe;
  logic             ser_clk_in = 1'b0;
  logic             loop_en = 1'b1;
  logic             rxd_drv = 1'b1;
  logic             cap_clk;

  int checks = 0, errors = 0;
  bit done = 0;
  int cap_n = 0;
  logic cap_bits [64];
  int clk_edges = 0;

  always #10 clk = ~clk;

  assign ser_rxd = loop_en ? ser_txd : rxd_drv;
  assign cap_clk = cfg_ext_clk ? ser_clk_in : ser_clk_out;

  always @(negedge cap_clk) if (cap_n < 64) begin
    cap_bits[cap_n] = ser_txd;
    cap_n++;
  end
  always @(posedge ser_clk_out) clk_edges++;

  sync_serial_port #(.DIV_W(DIV_W), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst(rst), .cfg_ext_clk(cfg_ext_clk), .cfg_fmt(cfg_fmt),
    .cfg_two_stop(cfg_two_stop), .cfg_div(cfg_div), .host_wr(host_wr),
    .host_rd(host_rd), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .tx_empty(tx_empty), .tx_busy(tx_busy),
    .rx_full(rx_full), .rx_overrun(rx_overrun), .ser_txd(ser_txd),
    .ser_rxd(ser_rxd), .ser_clk_in(ser_clk_in), .ser_clk_out(ser_clk_out),
    .ser_clk_oe(ser_clk_oe)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int flen_of(input logic [1:0] f, input bit two);
    int n;
    n = (f == 2'b00) ? 7 : (f == 2'b10) ? 9 : 8;
    return 1 + n + (two ? 2 : 1);
  endfunction

  function automatic logic [11:0] frame_of(input logic [8:0] d, input logic [1:0] f);
    logic [11:0] w;
    int n;
    n = (f == 2'b00) ? 7 : (f == 2'b10) ? 9 : 8;
    w = '1;
    w[0] = 1'b0;
    for (int i = 0; i < n; i++) w[i+1] = d[i];
    return w;
  endfunction

  function automatic logic [11:0] captured(input int base, input int len);
    logic [11:0] w;
    w = '1;
    for (int i = 0; i < len; i++) w[i] = cap_bits[base+i];
    return w;
  endfunction

  task automatic host_write(input logic [1:0] a, input logic [8:0] d);
    @(negedge clk); host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk); host_wr = 1'b0;
  endtask

  task automatic host_read(input logic [1:0] a, output logic [8:0] d);
    @(negedge clk); host_rd = 1'b1; host_addr = a;
    @(negedge clk); host_rd = 1'b0; d = host_rdata;
  endtask

  task automatic wait_idle();
    repeat (2) @(negedge clk);
    for (int i = 0; i < 5000; i++) begin
      if (!tx_busy) break;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(tx_empty == 1'b1 && tx_busy == 1'b0, "R1 tx flags", {tx_busy, tx_empty}, 1);
    chk(rx_full == 1'b0 && rx_overrun == 1'b0, "R1 rx flags", {rx_overrun, rx_full}, 0);
    chk(ser_txd == 1'b1 && ser_clk_out == 1'b0, "R1 lines", {ser_txd, ser_clk_out}, 2);
    chk(ser_clk_oe == 1'b1, "R3 clock pin driven", ser_clk_oe, 1);
  endtask

  task automatic t_idle();
    int e0;
    e0 = clk_edges;
    repeat (60) @(negedge clk);
    chk(clk_edges == e0 && ser_txd == 1'b1, "R1 idle quiet", clk_edges - e0, 0);
  endtask

  task automatic t_loop_char(input logic [1:0] f, input bit two, input logic [8:0] d,
                             input logic [8:0] exp_rx);
    int len, e0;
    time t0, t1;
    logic [8:0] rd;
    cfg_fmt = f; cfg_two_stop = two;
    len = flen_of(f, two);
    cap_n = 0; e0 = clk_edges;
    host_write(2'd0, d);
    @(posedge ser_clk_out); t0 = $time;
    @(negedge ser_clk_out); t1 = $time;
    chk((t1 - t0) == (cfg_div + 1) * 20, "R3 half period", int'(t1 - t0), (cfg_div + 1) * 20);
    wait_idle();
    chk(cap_n == len, "R3 edges per frame", cap_n, len);
    chk(clk_edges - e0 == len, "R3 rising count", clk_edges - e0, len);
    chk(captured(0, len) == frame_of(d, f), "R2 frame bits", captured(0, len), frame_of(d, f));
    chk(rx_full == 1'b1, "R7 full set", rx_full, 1);
    host_read(2'd0, rd);
    chk(rd == exp_rx, "R4 received data", rd, exp_rx);
    chk(rx_full == 1'b0, "R7 cleared by read", rx_full, 0);
  endtask

  task automatic t_back_to_back();
    logic [8:0] rd;
    cfg_fmt = 2'b01; cfg_two_stop = 1'b0;
    cap_n = 0;
    host_write(2'd0, 9'h05A);
    for (int i = 0; i < 100; i++) begin
      if (tx_empty) break;
      @(negedge clk);
    end
    chk(tx_empty == 1'b1 && tx_busy == 1'b1, "R5 moved to shifter", {tx_busy, tx_empty}, 3);
    host_write(2'd0, 9'h0C3);
    chk(tx_empty == 1'b0, "R5 cleared by write", tx_empty, 0);
    wait_idle();
    chk(cap_n == 20, "R6 no gap at busy drop", cap_n, 20);
    chk(captured(0, 10) == frame_of(9'h05A, 2'b01), "R6 first frame", captured(0, 10), frame_of(9'h05A, 2'b01));
    chk(captured(10, 10) == frame_of(9'h0C3, 2'b01), "R6 second frame", captured(10, 10), frame_of(9'h0C3, 2'b01));
    host_read(2'd1, rd);
    chk(rd == 9'h00D, "R10 status after overrun", rd, 9'h00D);
    host_read(2'd0, rd);
    chk(rd == 9'h0C3, "R8 buffer overwritten", rd, 9'h0C3);
    host_write(2'd1, 9'h000);
    host_read(2'd1, rd);
    chk(rd == 9'h009, "R8 sticky on write of 0", rd, 9'h009);
    host_write(2'd1, 9'h008);
    host_read(2'd1, rd);
    chk(rd == 9'h001, "R8 cleared by write of 1", rd, 9'h001);
  endtask

  task automatic t_external();
    logic [11:0] rf;
    logic [8:0] rd;
    int e0;
    cfg_fmt = 2'b01; cfg_two_stop = 1'b0;
    loop_en = 1'b0; rxd_drv = 1'b1;
    @(negedge clk); cfg_ext_clk = 1'b1;
    repeat (2) @(negedge clk);
    chk(ser_clk_oe == 1'b0, "R9 clock pin released", ser_clk_oe, 0);
    e0 = clk_edges; cap_n = 0;
    host_write(2'd0, 9'h096);
    repeat (4) @(negedge clk);
    rf = frame_of(9'h03C, 2'b01);
    for (int b = 0; b < 10; b++) begin
      ser_clk_in = 1'b1;
      @(negedge clk); rxd_drv = rf[b];
      repeat (7) @(negedge clk);
      ser_clk_in = 1'b0;
      repeat (8) @(negedge clk);
    end
    repeat (4) @(negedge clk);
    chk(captured(0, 10) == frame_of(9'h096, 2'b01), "R9 tx on external clock", captured(0, 10), frame_of(9'h096, 2'b01));
    chk(tx_busy == 1'b0 && rx_full == 1'b1, "R9 frame complete", {tx_busy, rx_full}, 1);
    chk(clk_edges == e0 && ser_clk_out == 1'b0, "R9 generated clock quiet", clk_edges - e0, 0);
    host_read(2'd0, rd);
    chk(rd == 9'h03C, "R9 rx on external clock", rd, 9'h03C);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_idle();
    t_loop_char(2'b01, 1'b0, 9'h0A5, 9'h0A5);
    t_loop_char(2'b00, 1'b1, 9'h1D5, 9'h055);
    t_loop_char(2'b10, 1'b0, 9'h1A3, 9'h1A3);
    t_loop_char(2'b11, 1'b1, 9'h13C, 9'h03C);
    t_back_to_back();
    t_external();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule